// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator with Boundary-Synchronised Updates

This block produces up to four independent pulse-width-modulated outputs. It is controlled through a small memory-mapped register bus. Each channel has a period count, a duty count, an output polarity and a power-of-two clock divider. The duty count gives the length of the inactive part of a period, and every period opens at the inactive level.

A running channel cannot be reprogrammed directly. New duty and period values are instead written to staging registers, and the channel adopts them at the next period boundary, so the waveform never shows a torn period. Channels are started and stopped through set-only enable and disable registers. A stop waits for the current period to complete. A per-channel flag, cleared when read, marks every period start, so software can tell that a staged value has been taken up.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, the status and period-start flag registers read 0, and every channel register reads 0.
- R2: Writing to the enable register (0x004) starts channel n for each set bit n, and writing to the disable register (0x008) requests a stop for each set bit n. Zero bits have no effect. Bit n of the status register (0x00C) reads 1 while channel n runs.
- R3: Channel n occupies the window at 0x200 + 32·n. Within the window the offsets are: mode at 0x00, duty at 0x04, staged duty at 0x08, period at 0x0C and staged period at 0x10. In the mode register, bits 3:0 hold the divider exponent p and bit 9 holds the polarity. A written p above 10 is stored as 10.
- R4: A running channel with period P, duty D and divider p is inactive for D·2^p clocks and then active for (P−D)·2^p clocks, in every period. D = 0 gives a permanently active output, and D ≥ P gives a permanently inactive output.
- R5: With polarity 0 the inactive level is low. With polarity 1 both levels are inverted, and this includes the idle level of a stopped channel.
- R6: A write to a staged register leaves the running waveform and the live register readback unchanged. The staged value reaches the live register at the next period boundary, and the staged register reads back the value written.
- R7: Direct writes to the mode, duty or period register of a running channel are ignored.
- R8: Bit n of the period-start flag register (0x01C) is set whenever channel n begins a period. Reading the register clears all of its bits.
- R9: A stop request takes effect at the end of the current period. The status bit stays 1 and the waveform continues until that point. Afterwards the output holds the inactive level.
- R10: When a channel is enabled, it begins a fresh period at the next divider tick. Any staged values still pending are applied as that period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| pwm_out | output | 4 | Waveform output, one bit per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counts and a divider limit of 10. Random configurations keep p between 0 and 2 and periods below 31 counts. This keeps every measured period under 130 clocks, so many complete periods fit in one run. Writing an exponent of 15 exercises the clamp at the divider limit. Long periods on one channel give room for staged writes, flag reads and stop requests to land mid-period, so boundary timing can be checked at the outputs.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int PRE_W   = 4;
  localparam int POL_BIT = 9;

  localparam int GLB_ENABLE  = 'h004;
  localparam int GLB_DISABLE = 'h008;
  localparam int GLB_STATUS  = 'h00C;
  localparam int GLB_FLAGS   = 'h01C;

  localparam int CH_BASE       = 'h200;
  localparam int CH_STRIDE_LG2 = 5;

  typedef enum logic [4:0] {
    OFS_MODE     = 5'h00,
    OFS_DUTY     = 5'h04,
    OFS_DUTY_STG = 5'h08,
    OFS_PRD      = 5'h0C,
    OFS_PRD_STG  = 5'h10
  } ch_ofs_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int MAX_PRE = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*PRE_W-1:0] pre_vec,
  output logic [NUM_CH-1:0]      tick_vec
);
  logic [MAX_PRE-1:0] div_q, div_d;

  always_comb div_d = div_q + MAX_PRE'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tick
    logic [MAX_PRE-1:0] mask;
    always_comb begin
      mask        = ~({MAX_PRE{1'b1}} << pre_vec[g*PRE_W +: PRE_W]);
      tick_vec[g] = (div_q & mask) == mask;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_PRE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en_set,
  input  logic             dis_set,
  input  logic             wr_mode,
  input  logic             wr_duty,
  input  logic             wr_duty_stg,
  input  logic             wr_prd,
  input  logic             wr_prd_stg,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             wr_pol,
  input  logic [PRE_W-1:0] wr_pre,
  output logic             pol_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] duty_stg_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] prd_stg_o,
  output logic             running_o,
  output logic             new_period_o,
  output logic             wave_o
);
  localparam logic [PRE_W-1:0] PRE_LIMIT = PRE_W'(MAX_PRE);

  logic             running_q, running_d;
  logic             start_q, start_d;
  logic             stop_q, stop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pol_q, pol_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] duty_q, duty_d, duty_stg_q, duty_stg_d;
  logic [CNT_W-1:0] prd_q, prd_d, prd_stg_q, prd_stg_d;
  logic             duty_pend_q, duty_pend_d, prd_pend_q, prd_pend_d;
  logic [CNT_W-1:0] last_cnt;
  logic             boundary;
  logic             new_period;
  logic [PRE_W-1:0] pre_clamped;

  always_comb begin
    last_cnt    = (prd_q == '0) ? '0 : prd_q - CNT_W'(1);
    boundary    = running_q && tick && (start_q || cnt_q == last_cnt);
    pre_clamped = (wr_pre > PRE_LIMIT) ? PRE_LIMIT : wr_pre;
  end

  always_comb begin
    running_d   = running_q;
    start_d     = start_q;
    stop_d      = stop_q;
    cnt_d       = cnt_q;
    pol_d       = pol_q;
    pre_d       = pre_q;
    duty_d      = duty_q;
    prd_d       = prd_q;
    duty_stg_d  = duty_stg_q;
    prd_stg_d   = prd_stg_q;
    duty_pend_d = duty_pend_q;
    prd_pend_d  = prd_pend_q;
    new_period  = 1'b0;

    if (!running_q) begin
      if (en_set) begin
        running_d = 1'b1;
        start_d   = 1'b1;
        stop_d    = 1'b0;
      end
      if (wr_mode) begin
        pol_d = wr_pol;
        pre_d = pre_clamped;
      end
      if (wr_duty) duty_d = wr_val;
      if (wr_prd)  prd_d  = wr_val;
    end else if (dis_set) begin
      stop_d = 1'b1;
    end

    if (boundary) begin
      cnt_d   = '0;
      start_d = 1'b0;
      if (stop_q) begin
        running_d = 1'b0;
        stop_d    = 1'b0;
      end else begin
        new_period = 1'b1;
        if (duty_pend_q) begin
          duty_d      = duty_stg_q;
          duty_pend_d = 1'b0;
        end
        if (prd_pend_q) begin
          prd_d      = prd_stg_q;
          prd_pend_d = 1'b0;
        end
      end
    end else if (running_q && tick && !start_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    if (wr_duty_stg) begin
      duty_stg_d  = wr_val;
      duty_pend_d = 1'b1;
    end
    if (wr_prd_stg) begin
      prd_stg_d  = wr_val;
      prd_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q   <= 1'b0;
      start_q     <= 1'b0;
      stop_q      <= 1'b0;
      cnt_q       <= '0;
      pol_q       <= 1'b0;
      pre_q       <= '0;
      duty_q      <= '0;
      prd_q       <= '0;
      duty_stg_q  <= '0;
      prd_stg_q   <= '0;
      duty_pend_q <= 1'b0;
      prd_pend_q  <= 1'b0;
    end else begin
      running_q   <= running_d;
      start_q     <= start_d;
      stop_q      <= stop_d;
      cnt_q       <= cnt_d;
      pol_q       <= pol_d;
      pre_q       <= pre_d;
      duty_q      <= duty_d;
      prd_q       <= prd_d;
      duty_stg_q  <= duty_stg_d;
      prd_stg_q   <= prd_stg_d;
      duty_pend_q <= duty_pend_d;
      prd_pend_q  <= prd_pend_d;
    end
  end

  always_comb begin
    wave_o       = (running_q && !start_q && cnt_q >= duty_q) ^ pol_q;
    new_period_o = new_period;
    running_o    = running_q;
    pol_o        = pol_q;
    pre_o        = pre_q;
    duty_o       = duty_q;
    prd_o        = prd_q;
    duty_stg_o   = duty_stg_q;
    prd_stg_o    = prd_stg_q;
  end

  AST_PRE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LIMIT); // R3
  AST_CNT_INSIDE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !start_q && prd_q != '0) |-> cnt_q < prd_q); // R4
  AST_LIVE_CHANGES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !boundary) |=> ($stable(duty_q) && $stable(prd_q))); // R6
  AST_DIRECT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && wr_mode) |=> ($stable(pol_q) && $stable(pre_q))); // R7
  AST_STOP_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_q) |-> $past(stop_q && boundary)); // R9
  AST_STOPPED_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_q) |-> (wave_o == pol_q)); // R9
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int MAX_PRE = 10,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(CH_BASE + (NUM_CH << CH_STRIDE_LG2));

  logic              wr_acc, rd_acc, in_window;
  logic [ADDR_W-1:0] win_ofs;
  logic [IDX_W-1:0]  ch_idx;
  ch_ofs_e           reg_ofs;
  logic              addr_unused;

  logic [NUM_CH-1:0]       tick_vec, running_vec, new_period_vec, wave_vec;
  logic [NUM_CH-1:0]       en_set, dis_set;
  logic [NUM_CH*PRE_W-1:0] pre_vec;
  logic                    pol_arr      [NUM_CH];
  logic [PRE_W-1:0]        pre_arr      [NUM_CH];
  logic [CNT_W-1:0]        duty_arr     [NUM_CH];
  logic [CNT_W-1:0]        duty_stg_arr [NUM_CH];
  logic [CNT_W-1:0]        prd_arr      [NUM_CH];
  logic [CNT_W-1:0]        prd_stg_arr  [NUM_CH];

  logic [NUM_CH-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, ch_rd;
  logic              rd_flags;
  logic              wdata_unused;

  always_comb begin
    wr_acc      = bus_sel && bus_wr;
    rd_acc      = bus_sel && !bus_wr;
    in_window   = (bus_addr >= WIN_LO) && (bus_addr < WIN_HI);
    win_ofs     = bus_addr - WIN_LO;
    ch_idx      = win_ofs[CH_STRIDE_LG2 +: IDX_W];
    reg_ofs     = ch_ofs_e'(bus_addr[CH_STRIDE_LG2-1:0]);
    addr_unused = ^win_ofs;
    wdata_unused = ^bus_wdata;
    rd_flags    = rd_acc && bus_addr == ADDR_W'(GLB_FLAGS);
    en_set      = (wr_acc && bus_addr == ADDR_W'(GLB_ENABLE))  ? bus_wdata[NUM_CH-1:0] : '0;
    dis_set     = (wr_acc && bus_addr == ADDR_W'(GLB_DISABLE)) ? bus_wdata[NUM_CH-1:0] : '0;
  end

  pwm_prescaler #(.NUM_CH(NUM_CH), .MAX_PRE(MAX_PRE)) i_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .pre_vec (pre_vec),
    .tick_vec(tick_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    always_comb hit = wr_acc && in_window && ch_idx == IDX_W'(g);

    pwm_channel #(.CNT_W(CNT_W), .MAX_PRE(MAX_PRE)) i_channel (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_vec[g]),
      .en_set      (en_set[g]),
      .dis_set     (dis_set[g]),
      .wr_mode     (hit && reg_ofs == OFS_MODE),
      .wr_duty     (hit && reg_ofs == OFS_DUTY),
      .wr_duty_stg (hit && reg_ofs == OFS_DUTY_STG),
      .wr_prd      (hit && reg_ofs == OFS_PRD),
      .wr_prd_stg  (hit && reg_ofs == OFS_PRD_STG),
      .wr_val      (bus_wdata[CNT_W-1:0]),
      .wr_pol      (bus_wdata[POL_BIT]),
      .wr_pre      (bus_wdata[PRE_W-1:0]),
      .pol_o       (pol_arr[g]),
      .pre_o       (pre_arr[g]),
      .duty_o      (duty_arr[g]),
      .duty_stg_o  (duty_stg_arr[g]),
      .prd_o       (prd_arr[g]),
      .prd_stg_o   (prd_stg_arr[g]),
      .running_o   (running_vec[g]),
      .new_period_o(new_period_vec[g]),
      .wave_o      (wave_vec[g])
    );

    always_comb pre_vec[g*PRE_W +: PRE_W] = pre_arr[g];
  end

  always_comb begin
    ch_rd = '0;
    unique case (reg_ofs)
      OFS_MODE: begin
        ch_rd[POL_BIT]     = pol_arr[ch_idx];
        ch_rd[PRE_W-1:0]   = pre_arr[ch_idx];
      end
      OFS_DUTY:     ch_rd = DATA_W'(duty_arr[ch_idx]);
      OFS_DUTY_STG: ch_rd = DATA_W'(duty_stg_arr[ch_idx]);
      OFS_PRD:      ch_rd = DATA_W'(prd_arr[ch_idx]);
      OFS_PRD_STG:  ch_rd = DATA_W'(prd_stg_arr[ch_idx]);
      default:      ch_rd = '0;
    endcase
  end

  always_comb begin
    flags_d = (rd_flags ? '0 : flags_q) | new_period_vec;
    rdata_d = rdata_q;
    if (rd_acc) begin
      if (in_window)                               rdata_d = ch_rd;
      else if (bus_addr == ADDR_W'(GLB_STATUS))    rdata_d = DATA_W'(running_vec);
      else if (bus_addr == ADDR_W'(GLB_FLAGS))     rdata_d = DATA_W'(flags_q);
      else                                         rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rdata_q <= '0;
    end else begin
      flags_q <= flags_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    bus_rdata = rdata_q;
    pwm_out   = wave_vec;
  end

  AST_FLAGS_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |=> (flags_q == $past(new_period_vec))); // R8
  AST_ENABLE_STARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set != '0) |=> ((running_vec & $past(en_set & ~running_vec)) == $past(en_set & ~running_vec))); // R2
  AST_FLAG_ON_NEW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (new_period_vec != '0) |=> ((flags_q & $past(new_period_vec)) == $past(new_period_vec))); // R8
endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [11:0] A_EN   = 12'h004;
  localparam logic [11:0] A_DIS  = 12'h008;
  localparam logic [11:0] A_STAT = 12'h00C;
  localparam logic [11:0] A_FLAG = 12'h01C;

  pwm_bank i_pwm_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [11:0] ch_addr(int ch, int ofs);
    return 12'(32'h200 + ch * 32 + ofs);
  endfunction

  function automatic int exp_active(int p, int d, int pre);
    return (d >= p) ? 0 : (p - d) << pre;
  endfunction

  function automatic int exp_inactive(int p, int d, int pre);
    return ((d >= p) ? p : d) << pre;
  endfunction

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_level(int ch, logic lvl);
    int n = 0;
    while (pwm_out[ch] !== lvl && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_level(int ch, logic lvl, int limit, output int n);
    n = 0;
    while (pwm_out[ch] === lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(int ch, logic pol, output int act, output int inact);
    wait_level(ch, pol);
    wait_level(ch, !pol);
    count_level(ch, !pol, 4000, act);
    count_level(ch, pol, 4000, inact);
  endtask

  task automatic stop_ch(int ch);
    logic [31:0] st;
    bus_write(A_DIS, 32'(1) << ch);
    for (int i = 0; i < 400; i++) begin
      bus_read(A_STAT, st);
      if (!st[ch]) break;
    end
  endtask

  task automatic setup_ch(int ch, int mode, int prd, int duty);
    bus_write(ch_addr(ch, 'h00), 32'(mode));
    bus_write(ch_addr(ch, 'h0C), 32'(prd));
    bus_write(ch_addr(ch, 'h04), 32'(duty));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int act, inact, n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1", "outputs", pwm_out, 0);
    bus_read(A_STAT, rd); check_eq("R1", "status", rd, 0);
    bus_read(A_FLAG, rd); check_eq("R1", "flags", rd, 0);
    bus_read(ch_addr(0, 'h0C), rd); check_eq("R1", "ch0 period", rd, 0);
    bus_read(ch_addr(2, 'h00), rd); check_eq("R1", "ch2 mode", rd, 0);

    // R3 clamp, R5 idle level with inverted polarity
    bus_write(ch_addr(1, 'h00), 32'h20F);
    bus_read(ch_addr(1, 'h00), rd); check_eq("R3", "mode clamp", rd, 32'h20A);
    check_eq("R5", "inverted idle level", pwm_out[1], 1);
    bus_write(ch_addr(1, 'h00), 32'h000);
    check_eq("R5", "normal idle level", pwm_out[1], 0);

    // R2 per-bit enable and disable
    setup_ch(2, 0, 20, 5);
    bus_write(A_EN, 32'h4);
    bus_read(A_STAT, rd); check_eq("R2", "status after enable", rd, 4);
    bus_write(A_EN, 32'h0);
    bus_write(A_DIS, 32'h0);
    bus_read(A_STAT, rd); check_eq("R2", "zero writes no effect", rd, 4);
    stop_ch(2);
    bus_read(A_STAT, rd); check_eq("R2", "status after disable", rd, 0);

    // R4 R5 random configurations
    for (int it = 0; it < 10; it++) begin
      int ch  = $urandom % 3;
      int pre = $urandom % 3;
      int p   = 4 + $urandom % 27;
      int d   = 1 + $urandom % (p - 1);
      int pol = $urandom % 2;
      setup_ch(ch, (pol << 9) | pre, p, d);
      bus_write(A_EN, 32'(1) << ch);
      measure(ch, pol[0], act, inact);
      check_eq("R4", "active length", act, exp_active(p, d, pre));
      check_eq("R4", "inactive length", inact, exp_inactive(p, d, pre));
      stop_ch(ch);
      check_eq("R5", "idle level after stop", pwm_out[ch], pol);
    end

    // R4 duty zero: permanently active
    setup_ch(0, 0, 8, 0);
    bus_write(A_EN, 32'h1);
    repeat (20) @(negedge clk);
    count_level(0, 1'b1, 40, n);
    check_eq("R4", "duty zero all active", n, 40);
    stop_ch(0);
    // R4 duty equal period: permanently inactive
    bus_write(ch_addr(0, 'h04), 32'd8);
    bus_write(A_EN, 32'h1);
    repeat (20) @(negedge clk);
    count_level(0, 1'b0, 40, n);
    check_eq("R4", "duty equal period all inactive", n, 40);
    stop_ch(0);

    // R7 direct writes ignored while running
    setup_ch(3, 0, 100, 50);
    bus_write(A_EN, 32'h8);
    bus_write(ch_addr(3, 'h0C), 32'd77);
    bus_read(ch_addr(3, 'h0C), rd); check_eq("R7", "period unchanged", rd, 100);
    bus_write(ch_addr(3, 'h04), 32'd9);
    bus_read(ch_addr(3, 'h04), rd); check_eq("R7", "duty unchanged", rd, 50);
    bus_write(ch_addr(3, 'h00), 32'h203);
    bus_read(ch_addr(3, 'h00), rd); check_eq("R7", "mode unchanged", rd, 0);

    // R6 staged duty
    wait_level(3, 1'b0);
    wait_level(3, 1'b1);
    bus_write(ch_addr(3, 'h08), 32'd80);
    bus_read(ch_addr(3, 'h04), rd); check_eq("R6", "live duty before boundary", rd, 50);
    bus_read(ch_addr(3, 'h08), rd); check_eq("R6", "staged duty readback", rd, 80);
    measure(3, 1'b0, act, inact);
    check_eq("R6", "active after staged duty", act, 20);
    check_eq("R6", "inactive after staged duty", inact, 80);
    bus_read(ch_addr(3, 'h04), rd); check_eq("R6", "live duty after boundary", rd, 80);
    // R6 staged period and duty together
    bus_write(ch_addr(3, 'h10), 32'd60);
    bus_write(ch_addr(3, 'h08), 32'd20);
    measure(3, 1'b0, act, inact);
    check_eq("R6", "active after staged period", act, 40);
    check_eq("R6", "inactive after staged period", inact, 20);

    // R8 flag set at period start, cleared by read
    wait_level(3, 1'b0);
    wait_level(3, 1'b1);
    bus_read(A_FLAG, rd); check_eq("R8", "flag set", rd[3], 1);
    bus_read(A_FLAG, rd); check_eq("R8", "flag cleared by read", rd[3], 0);

    // R9 deferred stop
    wait_level(3, 1'b0);
    wait_level(3, 1'b1);
    bus_write(A_DIS, 32'h8);
    bus_read(A_STAT, rd); check_eq("R9", "status held until period end", rd[3], 1);
    count_level(3, 1'b1, 4000, n);
    check_eq("R9", "active part completes", n, 36);
    count_level(3, 1'b0, 200, n);
    check_eq("R9", "output inactive after stop", n, 200);
    bus_read(A_STAT, rd); check_eq("R9", "status cleared", rd[3], 0);

    // R10 enable applies pending staged values
    setup_ch(0, 0, 30, 10);
    bus_write(ch_addr(0, 'h08), 32'd5);
    bus_read(A_FLAG, rd);
    bus_write(A_EN, 32'h1);
    measure(0, 1'b0, act, inact);
    check_eq("R10", "active with staged duty", act, 25);
    check_eq("R10", "inactive with staged duty", inact, 5);
    bus_read(ch_addr(0, 'h04), rd); check_eq("R10", "live duty taken from stage", rd, 5);
    bus_read(A_FLAG, rd); check_eq("R10", "period start flagged", rd[0], 1);
    stop_ch(0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule